// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves a data word between two tristate buses, called A and B. Each bus is modelled as three ports: an input, an output value and an output enable. One active-low enable and one direction input choose which bus, if any, is driven. Each direction has its own storage register with its own clock. A per-direction select decides whether the driven bus receives the live value from the opposite bus or the word held in that direction's register.

Each storage register captures its source bus on every rising edge of its own clock, whatever the enable, direction and select inputs are doing. This lets software-free sequencing park a word from either bus while both buses are isolated, and later present it. The data paths from bus to bus are combinational. A parameter inverts the data on both the live and the stored paths.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `enable_ni` is 1, both `a_oe_o` and `b_oe_o` are 0 for every value of `dir_i`, `sel_ab_i` and `sel_ba_i`.
- R2: While `enable_ni` is 0, `dir_i` = 0 gives `a_oe_o` = 1 and `b_oe_o` = 0, and `dir_i` = 1 gives `b_oe_o` = 1 and `a_oe_o` = 0.
- R3: `b_o` equals `a_i` when `sel_ab_i` is 0 and equals the A-to-B stored word when `sel_ab_i` is 1, in the same cycle and with no register on the path.
- R4: `a_o` equals `b_i` when `sel_ba_i` is 0 and equals the B-to-A stored word when `sel_ba_i` is 1.
- R5: Each rising edge of `clk_ab_i` loads `a_i` into the A-to-B store, including while both buses are isolated, and leaves the B-to-A store unchanged.
- R6: Each rising edge of `clk_ba_i` loads `b_i` into the B-to-A store, including while both buses are isolated, and leaves the A-to-B store unchanged.
- R7: `a_oe_o` and `b_oe_o` are never 1 at the same time.
- R8: With `INVERT` = 1, `a_o` and `b_o` carry the bitwise complement of the selected live or stored word; stores always hold the uninverted bus value.
- R9: `rst_ni` = 0 clears both stores to zero at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | Load clock of the A-to-B store |
| clk_ba_i | input | 1 | Load clock of the B-to-A store |
| rst_ni | input | 1 | Asynchronous active-low reset of both stores |
| enable_ni | input | 1 | Active-low drive enable; 1 isolates both buses |
| dir_i | input | 1 | 0: drive bus A from B side; 1: drive bus B from A side |
| sel_ab_i | input | 1 | Source for bus B: 0 live A, 1 stored word |
| sel_ba_i | input | 1 | Source for bus A: 0 live B, 1 stored word |
| a_i | input | W | Value sensed on bus A |
| a_o | output | W | Value offered to bus A |
| a_oe_o | output | 1 | Drive enable of bus A |
| b_i | input | W | Value sensed on bus B |
| b_o | output | W | Value offered to bus B |
| b_oe_o | output | 1 | Drive enable of bus B |

## Verification
The properties sample on the two store clocks, so they assume that bus values and control inputs are steady around each rising edge of `clk_ab_i` and `clk_ba_i`, as a setup and hold window would demand. The bench changes buses and controls only on the falling half of its own clock and raises each store clock a full half period later, keeping every property's sampled values settled. The load properties also assume the reset is never released at the same moment as a store clock edge, and the bench releases it with both store clocks low.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  typedef enum logic {
    XFER_TO_A = 1'b0,
    XFER_TO_B = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic a;
    logic b;
  } drive_en_t;
endpackage

// File: rtl/bus_xcvr_store.sv
module bus_xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/bus_xcvr_src_sel.sv
module bus_xcvr_src_sel #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] pick;

  assign pick = sel_i ? stored_i : live_i;

  generate
    if (INVERT) begin : g_inv
      assign data_o = ~pick;
    end else begin : g_pass
      assign data_o = pick;
    end
  endgenerate
endmodule

// File: rtl/bus_xcvr_drive_ctrl.sv
module bus_xcvr_drive_ctrl
  import bus_xcvr_pkg::*;
(
  input  logic      enable_ni,
  input  logic      dir_i,
  output drive_en_t drive_o
);
  xfer_dir_e dir;

  assign dir = xfer_dir_e'(dir_i);

  always_comb begin
    drive_o = '0;
    if (!enable_ni) begin
      if (dir == XFER_TO_B) drive_o.b = 1'b1;
      else                  drive_o.a = 1'b1;
    end
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bus_xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk_ab_i,
  input  logic         clk_ba_i,
  input  logic         rst_ni,
  input  logic         enable_ni,
  input  logic         dir_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [W-1:0] stored_ab_q;
  logic [W-1:0] stored_ba_q;
  drive_en_t    drive;

  // stores load on their own clock, independent of enable/dir/select
  bus_xcvr_store #(.W(W)) u_store_ab (
    .clk_i (clk_ab_i),
    .rst_ni(rst_ni),
    .d_i   (a_i),
    .q_o   (stored_ab_q)
  );

  bus_xcvr_store #(.W(W)) u_store_ba (
    .clk_i (clk_ba_i),
    .rst_ni(rst_ni),
    .d_i   (b_i),
    .q_o   (stored_ba_q)
  );

  bus_xcvr_src_sel #(.W(W), .INVERT(INVERT)) u_sel_to_b (
    .sel_i   (sel_ab_i),
    .live_i  (a_i),
    .stored_i(stored_ab_q),
    .data_o  (b_o)
  );

  bus_xcvr_src_sel #(.W(W), .INVERT(INVERT)) u_sel_to_a (
    .sel_i   (sel_ba_i),
    .live_i  (b_i),
    .stored_i(stored_ba_q),
    .data_o  (a_o)
  );

  bus_xcvr_drive_ctrl u_drive (
    .enable_ni(enable_ni),
    .dir_i    (dir_i),
    .drive_o  (drive)
  );

  assign a_oe_o = drive.a;
  assign b_oe_o = drive.b;
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         clk_ab_i,
  input logic         clk_ba_i,
  input logic         rst_ni,
  input logic         enable_ni,
  input logic         sel_ab_i,
  input logic         sel_ba_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_o,
  input logic         b_oe_o,
  input logic [W-1:0] stored_ab,
  input logic [W-1:0] stored_ba
);
  function automatic logic [W-1:0] xf(input logic [W-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  assert_one_driver_R7: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  assert_isolated_R1: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    enable_ni |-> (!a_oe_o && !b_oe_o));

  assert_load_ab_R5: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    1'b1 |=> (stored_ab == $past(a_i)));

  assert_load_ba_R6: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    1'b1 |=> (stored_ba == $past(b_i)));

  assert_live_to_b_R3: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (b_oe_o && !sel_ab_i) |-> (b_o == xf(a_i)));

  assert_stored_to_b_R3: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (b_oe_o && sel_ab_i) |-> (b_o == xf(stored_ab)));

  assert_live_to_a_R4: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (a_oe_o && !sel_ba_i) |-> (a_o == xf(b_i)));

  assert_stored_to_a_R4: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (a_oe_o && sel_ba_i) |-> (a_o == xf(stored_ba)));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk_ab_i (clk_ab_i),
  .clk_ba_i (clk_ba_i),
  .rst_ni   (rst_ni),
  .enable_ni(enable_ni),
  .sel_ab_i (sel_ab_i),
  .sel_ba_i (sel_ba_i),
  .a_i      (a_i),
  .a_o      (a_o),
  .a_oe_o   (a_oe_o),
  .b_i      (b_i),
  .b_o      (b_o),
  .b_oe_o   (b_oe_o),
  .stored_ab(stored_ab_q),
  .stored_ba(stored_ba_q)
);

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb;
  localparam int W = 8;

  // {enable_n, dir, sel_ab, sel_ba, exp a_oe, exp b_oe}
  localparam logic [5:0] VEC [16] = '{
    6'b0000_10, 6'b0001_10, 6'b0010_10, 6'b0011_10,
    6'b0100_01, 6'b0101_01, 6'b0110_01, 6'b0111_01,
    6'b1000_00, 6'b1001_00, 6'b1010_00, 6'b1011_00,
    6'b1100_00, 6'b1101_00, 6'b1110_00, 6'b1111_00
  };

  logic clk = 1'b0;
  logic clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic en_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out, a_out_x, b_out_x;
  logic a_oe, b_oe, a_oe_x, b_oe_x;
  int total = 0, bad = 0, cycles = 0;
  logic [W-1:0] st_ab, st_ba;

  always #5 clk = ~clk;

  bus_xcvr_reg #(.W(W), .INVERT(1'b0)) u_dut (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n), .enable_ni(en_n),
    .dir_i(dir), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  bus_xcvr_reg #(.W(W), .INVERT(1'b1)) u_inv (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n), .enable_ni(en_n),
    .dir_i(dir), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_i(a_in), .a_o(a_out_x), .a_oe_o(a_oe_x),
    .b_i(b_in), .b_o(b_out_x), .b_oe_o(b_oe_x)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse_ab();
    @(negedge clk); clk_ab = 1'b1;
    @(negedge clk); clk_ab = 1'b0;
  endtask

  task automatic pulse_ba();
    @(negedge clk); clk_ba = 1'b1;
    @(negedge clk); clk_ba = 1'b0;
  endtask

  task automatic set_ctl(input logic e, input logic d, input logic sab, input logic sba);
    @(negedge clk);
    en_n = e; dir = d; sel_ab = sab; sel_ba = sba;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: got %0d expected below 100000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: stores read back zero through the stored path during reset
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    a_in = 8'hFF; b_in = 8'hFF; #1;
    chk("R9 reset A-to-B store", b_out, 8'h00);
    chk("R9 reset B-to-A store", a_out, 8'h00);
    chk("R8 R9 inverted reset view", b_out_x, 8'hFF);
    @(negedge clk); rst_n = 1'b1;

    // R5 R6: load both stores while isolated
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    a_in = 8'h3C; b_in = 8'hA5;
    pulse_ab();
    pulse_ba();
    st_ab = 8'h3C; st_ba = 8'hA5;
    @(negedge clk); a_in = 8'h81; b_in = 8'h5A;

    // R1 R2 R3 R4 R7 R8: every control combination
    for (int i = 0; i < 16; i++) begin
      set_ctl(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk("R1 R2 a_oe", {7'd0, a_oe}, {7'd0, VEC[i][1]});
      chk("R1 R2 b_oe", {7'd0, b_oe}, {7'd0, VEC[i][0]});
      chk("R7 single driver", {7'd0, a_oe & b_oe}, 8'd0);
      chk("R3 data to B", b_out, VEC[i][3] ? st_ab : a_in);
      chk("R4 data to A", a_out, VEC[i][2] ? st_ba : b_in);
      chk("R8 inverted to B", b_out_x, ~(VEC[i][3] ? st_ab : a_in));
      chk("R8 inverted to A", a_out_x, ~(VEC[i][2] ? st_ba : b_in));
      chk("R8 inverted oe", {6'd0, a_oe_x, b_oe_x}, {6'd0, VEC[i][1:0]});
    end

    // R5: A-to-B clock while driving A, other store untouched
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
    a_in = 8'hC3; b_in = 8'h0F;
    pulse_ab();
    @(negedge clk); a_in = 8'h00; b_in = 8'h00; #1;
    chk("R5 store keeps B-to-A word", a_out, 8'hA5);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R5 new A-to-B word", b_out, 8'hC3);

    // R6: B-to-A clock, A-to-B store untouched
    b_in = 8'h96; a_in = 8'h11;
    pulse_ba();
    @(negedge clk); b_in = 8'h00; a_in = 8'h00; #1;
    chk("R6 store keeps A-to-B word", b_out, 8'hC3);
    chk("R6 new B-to-A word", a_out, 8'h96);
    chk("R6 R8 inverted stored word", a_out_x, 8'h69);

    // R3: live path follows bus with no clock
    set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
    a_in = 8'h7E; #1;
    chk("R3 live path no clock", b_out, 8'h7E);

    // R9: asynchronous clear mid-run, no store clock
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
    rst_n = 1'b0; #1;
    chk("R9 async clear A-to-B", b_out, 8'h00);
    chk("R9 async clear B-to-A", a_out, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule